// File: doc/BRIEF.md
# Compensated Logarithmic Approximate Multiplier

This block multiplies two unsigned W-bit operands approximately, using the logarithmic method. Each operand is reduced to a characteristic, which is the index of its highest set bit, and a binary fraction made from the bits below that one. The two logarithms are summed. The product is rebuilt by shifting the mantissa left by the summed characteristics. A small correction is added before the shift. The correction comes from the two leading fraction bits of each operand and stands in for the cross term that the plain method drops. The plain method always rounds low. With the correction, the residual error falls on both sides of the exact product, and its mean magnitude is smaller.

The block suits error-tolerant datapaths, such as filters and neural network inference, where area and power matter more than exact low-order bits. The saving compared with an array multiplier grows with operand width. A parameter removes the correction, which gives plain logarithmic multiplication for comparison. There is one register stage: operands with a valid strobe go in, and a 2W-bit product with a valid flag comes out one clock later.

Top module: `approx_log_mult`

## Requirements
- R1: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low in the cycle after an edge at which `in_valid` was low.
- R2: Reset clears `product` and `out_valid` to 0. While `in_valid` is low, `product` keeps its previous value.
- R3: If either operand is 0, the registered product is exactly 0.
- R4: For a nonzero operand x, the characteristic k is the index of its highest set bit, and the fraction is f = (x - 2^k) / 2^k. The leading fraction-bit pair t = floor(4f) lies in the range 0..3.
- R5: When fa + fb < 1 and compensation is on, the result is floor(2^(ka+kb) * (1 + fa + fb + (2ta+1)(2tb+1)/64)).
- R6: When fa + fb >= 1 and compensation is on, the result is floor(2^(ka+kb+1) * (fa + fb + (7-2ta)(7-2tb)/128)).
- R7: Results are truncated toward zero. A value above 2^(2W)-1 is clamped to all ones.
- R8: With compensation off (COMP=0), the result is floor(2^(ka+kb)(1+fa+fb)) without carry and floor(2^(ka+kb+1)(fa+fb)) with carry. It never exceeds the exact product.
- R9: With compensation on, the sweep over all nonzero operand pairs contains both results above and results below the exact product. Its mean relative error is lower than with compensation off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| out_valid | output | 1 | Product register holds a new result |
| product | output | 2W | Approximate product |

## Verification
Some properties are checked on every cycle. These are the one-cycle valid latency, the product holding while no operands arrive, and the forced zero for a zero operand. With compensation off, every result also stays at or below the exact product. Inside the encoder, a check confirms that shifting the operand right by its characteristic leaves exactly one. The two carry rules, the bin-centre correction, truncation, and the statistical claim of two-sided error with a lower mean need scenarios. A directed vector table and an exhaustive operand sweep show these, compared against a model that works in real arithmetic.

// File: rtl/logmul_pkg.sv
package logmul_pkg;

  // Product of two bin centres, each written as an odd number over 8:
  // (2x+1)*(2y+1). Largest value 7*7 = 49, fits in 6 bits.
  function automatic logic [5:0] center_prod(input logic [1:0] x, input logic [1:0] y);
    logic [5:0] cx;
    logic [5:0] cy;
    cx = {3'b000, x, 1'b1};
    cy = {3'b000, y, 1'b1};
    return cx * cy;
  endfunction

endpackage

// File: rtl/lead_one_enc.sv
module lead_one_enc #(
  parameter int W = 8
) (
  input  logic [W-1:0]         opnd,
  output logic [$clog2(W)-1:0] pos,
  output logic [W-2:0]         frac,
  output logic                 nonzero
);
  localparam int FB = W - 1;
  localparam int KW = $clog2(W);

  function automatic logic [KW-1:0] msb_index(input logic [W-1:0] v);
    logic [KW-1:0] idx;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (v[i]) idx = KW'(i);
    end
    return idx;
  endfunction

  logic [W-1:0] aligned;

  always_comb begin
    pos     = msb_index(opnd);
    aligned = opnd << (KW'(FB) - pos);
    frac    = aligned[FB-1:0];
    nonzero = |opnd;
    // R4
    if (nonzero) begin
      lod_norm_chk: assert ((opnd >> pos) == W'(1));
    end
  end

endmodule

// File: rtl/err_comp.sv
module err_comp #(
  parameter int FB   = 7,     // fraction bits, must be at least 7
  parameter bit COMP = 1'b1
) (
  input  logic [1:0]    top_a,
  input  logic [1:0]    top_b,
  input  logic          carry,
  output logic [FB-1:0] corr
);
  import logmul_pkg::*;

  localparam int SH_LO = FB - 6;   // no-carry term is cp/64
  localparam int SH_HI = FB - 7;   // carry term is cp/128

  generate
    if (COMP) begin : g_on
      logic [5:0] cp;
      // no carry: estimate fa*fb from bin centres
      // carry: estimate (1-fa)(1-fb)/2 from complemented bins
      assign cp   = carry ? center_prod(~top_a, ~top_b) : center_prod(top_a, top_b);
      assign corr = carry ? (FB'(cp) << SH_HI) : (FB'(cp) << SH_LO);
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{top_a, top_b, carry};
      assign corr = '0;
    end
  endgenerate

endmodule

// File: rtl/antilog_shift.sv
module antilog_shift #(
  parameter int W = 8
) (
  input  logic [$clog2(W)-1:0] k_a,
  input  logic [$clog2(W)-1:0] k_b,
  input  logic [W-1:0]         fsum,   // FB+1 bits, top bit is the carry
  input  logic [W-2:0]         corr,
  output logic [2*W-1:0]       prod
);
  localparam int FB = W - 1;
  localparam int EW = $clog2(2 * W);
  localparam int MW = FB + 2;
  localparam int SW = MW + 2 * W - 1;

  logic [MW-1:0] mant;
  logic [EW-1:0] expo;
  logic [SW-1:0] wide;
  logic [2*W:0]  scaled;

  always_comb begin
    // 1.f in both cases: without carry 1+fsum, with carry fsum itself
    mant   = {1'b0, 1'b1, fsum[FB-1:0]} + {2'b00, corr};
    expo   = EW'(k_a) + EW'(k_b) + EW'(fsum[FB]);
    wide   = SW'(mant) << expo;
    scaled = wide[SW-1:FB];
    prod   = scaled[2*W] ? '1 : scaled[2*W-1:0];
  end

endmodule

// File: rtl/approx_log_mult.sv
module approx_log_mult #(
  parameter int W    = 8,      // operand width, at least 8
  parameter bit COMP = 1'b1    // 1: two-sided correction, 0: plain method
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int FB = W - 1;
  localparam int KW = $clog2(W);

  logic [W-1:0]  opnd [2];
  logic [KW-1:0] pos  [2];
  logic [FB-1:0] frac [2];
  logic [1:0]    nz;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_enc
      lead_one_enc #(.W(W)) u_enc (
        .opnd    (opnd[g]),
        .pos     (pos[g]),
        .frac    (frac[g]),
        .nonzero (nz[g])
      );
    end
  endgenerate

  logic [FB:0]     fsum;
  logic            carry_evt;
  logic            zero_evt;
  logic [FB-1:0]   corr;
  logic [2*W-1:0]  approx;
  logic [2*W-1:0]  next_prod;

  assign fsum      = {1'b0, frac[0]} + {1'b0, frac[1]};
  assign carry_evt = fsum[FB];
  assign zero_evt  = ~(nz[0] & nz[1]);

  err_comp #(.FB(FB), .COMP(COMP)) u_comp (
    .top_a (frac[0][FB-1 -: 2]),
    .top_b (frac[1][FB-1 -: 2]),
    .carry (carry_evt),
    .corr  (corr)
  );

  antilog_shift #(.W(W)) u_alog (
    .k_a  (pos[0]),
    .k_b  (pos[1]),
    .fsum (fsum),
    .corr (corr),
    .prod (approx)
  );

  assign next_prod = zero_evt ? '0 : approx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= next_prod;
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));
  // R3
  zero_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_a == '0 || op_b == '0)) |=> (product == '0));

  generate
    if (!COMP) begin : g_plain_chk
      logic [2*W-1:0] exact_ab;
      assign exact_ab = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
      // R8
      never_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (product <= $past(exact_ab)));
    end
  endgenerate

endmodule

// File: tb/approx_log_mult_tb_top.sv
`timescale 1ns/1ps
module approx_log_mult_tb_top;
  localparam int W    = 8;
  localparam int PMAX = (1 << (2 * W)) - 1;
  localparam int NV   = 10;

  // operand a, operand b, expected with correction, expected without
  localparam int VA [NV] = '{0,   255, 1, 2, 3, 128,   255,   6,  7, 1};
  localparam int VB [NV] = '{200, 0,   1, 2, 3, 128,   255,   5,  7, 255};
  localparam int VC [NV] = '{0,   0,   1, 4, 8, 16640, 65280, 31, 48, 269};
  localparam int VN [NV] = '{0,   0,   1, 4, 8, 16384, 65024, 28, 48, 255};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [W-1:0]   op_a = '0;
  logic [W-1:0]   op_b = '0;
  logic           vld_c, vld_n;
  logic [2*W-1:0] prod_c, prod_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  approx_log_mult #(.W(W), .COMP(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(vld_c), .product(prod_c));

  approx_log_mult #(.W(W), .COMP(1'b0)) dut_plain_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(vld_n), .product(prod_n));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Independent model in real arithmetic
  function automatic longint model(input int a, input int b, input bit comp);
    int ka, kb, ta, tb;
    real fa, fb, s, v;
    longint r;
    if (a == 0 || b == 0) return 0;
    ka = 0; while ((a >> (ka + 1)) != 0) ka++;
    kb = 0; while ((b >> (kb + 1)) != 0) kb++;
    fa = real'(a - (1 << ka)) / real'(1 << ka);
    fb = real'(b - (1 << kb)) / real'(1 << kb);
    ta = int'($floor(fa * 4.0));
    tb = int'($floor(fb * 4.0));
    s  = fa + fb;
    if (s < 1.0) begin
      v = 1.0 + s;
      if (comp) v = v + real'((2*ta+1)*(2*tb+1)) / 64.0;
      v = v * (2.0 ** (ka + kb));
    end else begin
      v = s;
      if (comp) v = v + real'((7-2*ta)*(7-2*tb)) / 128.0;
      v = v * (2.0 ** (ka + kb + 1));
    end
    r = longint'($floor(v));
    if (r > PMAX) r = PMAX;
    return r;
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int npos, nneg, nover_plain;
    real sum_c, sum_n, ex;
    logic [2*W-1:0] held;

    // R2: reset state
    repeat (3) @(negedge clk);
    check(prod_c == '0 && vld_c == 1'b0, "R2 reset product/valid", prod_c, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vld_c == 1'b0, "R1 idle valid low", vld_c, 0);

    // Vector table, R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      op_a = W'(VA[i]); op_b = W'(VB[i]); in_valid = 1'b1;
      @(negedge clk);
      check(vld_c == 1'b1, "R1 valid after one cycle", vld_c, 1);
      check(prod_c == (2*W)'(VC[i]), "R5/R6 table compensated", prod_c, VC[i]);
      check(prod_n == (2*W)'(VN[i]), "R8 table plain", prod_n, VN[i]);
    end

    // R1 R2: drop valid, product holds, operands ignored
    held = prod_c;
    in_valid = 1'b0; op_a = 8'd77; op_b = 8'd91;
    @(negedge clk);
    check(vld_c == 1'b0, "R1 valid drop", vld_c, 0);
    check(prod_c == held, "R2 hold without valid", prod_c, held);
    @(negedge clk);
    check(prod_c == held, "R2 hold second cycle", prod_c, held);

    // R3: zero on one side after a nonzero result
    op_a = 8'd200; op_b = 8'd150; in_valid = 1'b1;
    @(negedge clk);
    op_a = 8'd0; op_b = 8'd150;
    @(negedge clk);
    check(prod_c == '0 && prod_n == '0, "R3 zero operand", prod_c, 0);

    // Exhaustive sweep: R4 R5 R6 R7 R8 R9
    npos = 0; nneg = 0; nover_plain = 0; sum_c = 0.0; sum_n = 0.0;
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        longint ec, en;
        op_a = W'(a); op_b = W'(b); in_valid = 1'b1;
        @(negedge clk);
        ec = model(a, b, 1'b1);
        en = model(a, b, 1'b0);
        check(longint'(prod_c) == ec, "R4/R5/R6/R7 sweep compensated", prod_c, ec);
        check(longint'(prod_n) == en, "R8 sweep plain", prod_n, en);
        if (a != 0 && b != 0) begin
          ex = real'(a * b);
          if (real'(prod_c) > ex) npos++;
          if (real'(prod_c) < ex) nneg++;
          if (real'(prod_n) > ex) nover_plain++;
          sum_c = sum_c + ((real'(prod_c) > ex) ? real'(prod_c) - ex : ex - real'(prod_c)) / ex;
          sum_n = sum_n + ((real'(prod_n) > ex) ? real'(prod_n) - ex : ex - real'(prod_n)) / ex;
        end
      end
    end
    in_valid = 1'b0;

    check(nover_plain == 0, "R8 plain never above exact", nover_plain, 0);
    check(npos > 0, "R9 some results above exact", npos, 1);
    check(nneg > 0, "R9 some results below exact", nneg, 1);
    check(sum_c < sum_n, "R9 mean relative error lower (x1e6)",
          longint'(sum_c * 1.0e6 / 65025.0), longint'(sum_n * 1.0e6 / 65025.0));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule